// File: doc/BRIEF.md
# Pilot-Aided Phase Linear Interpolator

This block performs feedforward carrier phase recovery on a symbol stream whose carrier frequency has already been corrected. Pilot blocks of known symbols repeat through the stream, with a fixed run of data symbols between every two blocks. For each pilot block the block strips the known modulation from every pilot sample and accumulates the products. It then takes the argument of the sum with an iterative vectoring rotator. The result is one phase estimate per pilot block.

The block keeps the estimate of the previous pilot block. Once a new estimate is ready, it takes the shortest-path phase step between the two estimates. It then emits one interpolated phase for each data symbol that lay between the two blocks, one per clock cycle, each tagged with the symbol's position in the gap. These phases drive a downstream phase rotator. The data symbols are delayed elsewhere until the phase that follows them is ready.

Phases are 16-bit two's-complement numbers in which 32768 LSB equal π. A value of -32768 stands for π, and every wrap into (−π, π] happens through natural overflow. With N data symbols between pilot blocks, the interpolation distance is D = N + 1. The reciprocal of D is computed when the block is elaborated, so no divider is built.

Top module: `pilot_phase_interp`

## Requirements
- R1: After reset, `out_valid` is low, and it stays low until a second complete pilot block has been processed.
- R2: The first pilot block after reset only sets the reference phase; it produces no output sweep.
- R3: Each pilot block's estimate is the argument of Σ r[k]·conj(p[k]) over the block's pilots. The known pilot is p = (ref_i_neg ? −1 : +1) + j·(ref_q_neg ? −1 : +1). The estimate is accurate to within a few LSB.
- R4: All phases are signed 16-bit values where +16384 is π/2 and −32768 is π.
- R5: Each pilot block after the first yields exactly N consecutive cycles of `out_valid`. `out_idx` runs 1, 2, …, N on those cycles, and `out_valid` then drops.
- R6: For output index i the phase is prev + round(Δ·i/D), where D = N + 1 and Δ = cur − prev is wrapped into (−π, π], so the interpolation takes the shorter way round the circle.
- R7: The interpolated phase is wrapped into (−π, π]; a path that crosses ±π continues from the opposite sign.
- R8: Samples with `in_pilot` low, and any cycle with `in_valid` low, have no effect on the estimate.
- R9: After each sweep the current block estimate becomes the previous estimate for the next pilot block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_i | input | SAMPLE_W | In-phase component, signed |
| in_q | input | SAMPLE_W | Quadrature component, signed |
| in_pilot | input | 1 | Sample belongs to a pilot block |
| ref_i_neg | input | 1 | Known pilot real part is −1 (else +1) |
| ref_q_neg | input | 1 | Known pilot imaginary part is −1 (else +1) |
| out_valid | output | 1 | Interpolated phase present this cycle |
| out_idx | output | clog2(DATA_LEN+1) | Data symbol position in the gap, 1..DATA_LEN |
| out_phase | output | 16 | Interpolated phase correction |

## Verification
The bench drives a chain of twenty pilot blocks. Their rotations are chosen so that consecutive phase steps cover small moves, steps up to about 165 degrees in both directions, and pairs that straddle ±π. This separates correct shortest-path wrapping from naive subtraction and from output wrapping faults. The known pilot pattern cycles through all four sign codes within and across blocks, which checks the conjugate derotation. Full-scale junk data samples and stalled cycles that carry a raised pilot flag are mixed into the stream, so any leak into the accumulator shows up as a phase error. The first block is checked for silence, and every later sweep is checked for its exact length, index order and per-index interpolated phase.

// File: rtl/pilot_phase_interp_pkg.sv
package pilot_phase_interp_pkg;

    // Phase word: two's complement, 32768 LSB = pi
    localparam int PHASE_W = 16;
    typedef logic signed [PHASE_W-1:0] phase_t;

    // Arctangent of 2^-k in phase units (pi = 32768)
    function automatic phase_t atan_step(input int k);
        case (k)
            0:  return 16'sd8192;
            1:  return 16'sd4836;
            2:  return 16'sd2555;
            3:  return 16'sd1297;
            4:  return 16'sd651;
            5:  return 16'sd326;
            6:  return 16'sd163;
            7:  return 16'sd81;
            8:  return 16'sd41;
            9:  return 16'sd20;
            10: return 16'sd10;
            11: return 16'sd5;
            12: return 16'sd3;
            13: return 16'sd1;
            14: return 16'sd1;
            default: return 16'sd0;
        endcase
    endfunction

endpackage

// File: rtl/pai_pilot_accum.sv
module pai_pilot_accum #(
    parameter int SW        = 12,
    parameter int PILOT_LEN = 36,
    parameter int SUMW      = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [SW-1:0]   in_i,
    input  logic signed [SW-1:0]   in_q,
    input  logic                   in_pilot,
    input  logic                   ref_i_neg,
    input  logic                   ref_q_neg,
    output logic                   blk_done,
    output logic signed [SUMW-1:0] blk_sum_i,
    output logic signed [SUMW-1:0] blk_sum_q
);
    localparam int CNTW = $clog2(PILOT_LEN) + 1;
    localparam logic [CNTW-1:0] LAST = CNTW'(PILOT_LEN - 1);

    typedef struct packed {
        logic signed [SUMW-1:0] acc_i;
        logic signed [SUMW-1:0] acc_q;
        logic [CNTW-1:0]        cnt;
        logic                   done;
        logic signed [SUMW-1:0] sum_i;
        logic signed [SUMW-1:0] sum_q;
    } acc_state_t;

    acc_state_t s_d, s_q;

    logic signed [SUMW-1:0] ri, rq, term_i, term_q;

    always_comb begin
        ri = SUMW'(in_i);
        rq = SUMW'(in_q);
        // r * conj(p) with p = a + jb, a,b in {+1,-1}
        term_i = (ref_i_neg ? -ri : ri) + (ref_q_neg ? -rq : rq);
        term_q = (ref_i_neg ? -rq : rq) - (ref_q_neg ? -ri : ri);

        s_d      = s_q;
        s_d.done = 1'b0;
        if (in_valid && in_pilot) begin
            if (s_q.cnt == LAST) begin
                s_d.sum_i = s_q.acc_i + term_i;
                s_d.sum_q = s_q.acc_q + term_q;
                s_d.done  = 1'b1;
                s_d.acc_i = '0;
                s_d.acc_q = '0;
                s_d.cnt   = '0;
            end else begin
                s_d.acc_i = s_q.acc_i + term_i;
                s_d.acc_q = s_q.acc_q + term_q;
                s_d.cnt   = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign blk_done  = s_q.done;
    assign blk_sum_i = s_q.sum_i;
    assign blk_sum_q = s_q.sum_q;

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_pilot) |=> ($stable(s_q.acc_i) && $stable(s_q.acc_q) && $stable(s_q.cnt)));

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> (s_q.cnt == '0));

endmodule

// File: rtl/pai_cordic_vec.sv
module pai_cordic_vec
    import pilot_phase_interp_pkg::*;
#(
    parameter int IW   = 20,
    parameter int ITER = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic signed [IW-1:0] x_in,
    input  logic signed [IW-1:0] y_in,
    output logic                 done,
    output phase_t               angle
);
    localparam int CW = IW + 2;
    localparam int KW = $clog2(ITER) + 1;
    localparam logic [KW-1:0] KLAST = KW'(ITER - 1);

    typedef struct packed {
        logic                 busy;
        logic [KW-1:0]        k;
        logic signed [CW-1:0] x;
        logic signed [CW-1:0] y;
        phase_t               z;
        logic                 done;
        phase_t               angle;
    } cor_state_t;

    cor_state_t s_d, s_q;

    logic signed [CW-1:0] xe, ye, xs, ys, xn, yn;
    phase_t               zn;

    always_comb begin
        xe = CW'(x_in);
        ye = CW'(y_in);
        xs = s_q.x >>> s_q.k;
        ys = s_q.y >>> s_q.k;
        if (!s_q.y[CW-1]) begin
            xn = s_q.x + ys;
            yn = s_q.y - xs;
            zn = s_q.z + atan_step(int'(s_q.k));
        end else begin
            xn = s_q.x - ys;
            yn = s_q.y + xs;
            zn = s_q.z - atan_step(int'(s_q.k));
        end

        s_d      = s_q;
        s_d.done = 1'b0;
        if (start) begin
            s_d.busy = 1'b1;
            s_d.k    = '0;
            if (!xe[CW-1]) begin
                s_d.x = xe;
                s_d.y = ye;
                s_d.z = '0;
            end else if (!ye[CW-1]) begin
                // left half-plane, upper: turn by -pi/2
                s_d.x = ye;
                s_d.y = -xe;
                s_d.z = 16'sd16384;
            end else begin
                // left half-plane, lower: turn by +pi/2
                s_d.x = -ye;
                s_d.y = xe;
                s_d.z = -16'sd16384;
            end
        end else if (s_q.busy) begin
            s_d.x = xn;
            s_d.y = yn;
            s_d.z = zn;
            s_d.k = s_q.k + 1'b1;
            if (s_q.k == KLAST) begin
                s_d.busy  = 1'b0;
                s_d.done  = 1'b1;
                s_d.angle = zn;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done  = s_q.done;
    assign angle = s_q.angle;

    // R3
    cordic_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !s_q.busy);

    // R3
    cordic_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> $past(s_q.busy));

endmodule

// File: rtl/pai_interp.sv
module pai_interp
    import pilot_phase_interp_pkg::*;
#(
    parameter int DATA_LEN = 1440,
    parameter int IDXW     = 11,
    parameter int RS       = 28
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            est_valid,
    input  phase_t          est_phase,
    output logic            out_valid,
    output logic [IDXW-1:0] out_idx,
    output phase_t          out_phase
);
    localparam int DIST = DATA_LEN + 1;
    localparam int AW   = PHASE_W + RS + 2 + IDXW;
    localparam logic [63:0] RECIP_L = ((64'd1 << RS) + 64'(DIST / 2)) / 64'(DIST);
    localparam logic signed [AW-1:0] RECIP = AW'(RECIP_L);
    localparam logic signed [AW-1:0] HALF  = AW'(64'd1 << (RS - 1));
    localparam logic [IDXW-1:0] ILAST = IDXW'(DATA_LEN);

    typedef struct packed {
        logic                 busy;
        logic                 prev_ok;
        phase_t               prev;
        phase_t               base;
        logic signed [AW-1:0] step;
        logic signed [AW-1:0] acc;
        logic [IDXW-1:0]      idx;
        logic                 ovalid;
        logic [IDXW-1:0]      oidx;
        phase_t               ophase;
    } int_state_t;

    int_state_t s_d, s_q;

    phase_t               diff;
    logic signed [AW-1:0] diff_ext, rnd;

    always_comb begin
        // shortest-path step: wraps by overflow of the 16-bit difference
        diff     = est_phase - s_q.prev;
        diff_ext = AW'(diff);
        rnd      = s_q.acc + HALF;

        s_d        = s_q;
        s_d.ovalid = 1'b0;
        if (s_q.busy) begin
            s_d.ovalid = 1'b1;
            s_d.oidx   = s_q.idx;
            s_d.ophase = s_q.base + phase_t'(rnd[RS +: PHASE_W]);
            s_d.acc    = s_q.acc + s_q.step;
            s_d.idx    = s_q.idx + 1'b1;
            if (s_q.idx == ILAST) s_d.busy = 1'b0;
        end
        if (est_valid) begin
            s_d.prev    = est_phase;
            s_d.prev_ok = 1'b1;
            if (s_q.prev_ok) begin
                s_d.busy = 1'b1;
                s_d.base = s_q.prev;
                s_d.step = diff_ext * RECIP;
                s_d.acc  = diff_ext * RECIP;
                s_d.idx  = IDXW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.ovalid;
    assign out_idx   = s_q.oidx;
    assign out_phase = s_q.ophase;

    // R2
    first_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> s_q.prev_ok);

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid |-> !s_q.busy);

    // R5
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_idx != '0 && out_idx <= ILAST));

    // R5
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idx != ILAST) |=> (out_valid && out_idx == $past(out_idx) + 1'b1));

    // R5
    sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idx == ILAST) |=> !out_valid);

endmodule

// File: rtl/pilot_phase_interp.sv
module pilot_phase_interp
    import pilot_phase_interp_pkg::*;
#(
    parameter int SAMPLE_W    = 12,
    parameter int PILOT_LEN   = 36,
    parameter int DATA_LEN    = 1440,
    parameter int CORDIC_ITER = 14,
    parameter int RECIP_SHIFT = 28,
    localparam int IDXW       = $clog2(DATA_LEN + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_i,
    input  logic signed [SAMPLE_W-1:0] in_q,
    input  logic                       in_pilot,
    input  logic                       ref_i_neg,
    input  logic                       ref_q_neg,
    output logic                       out_valid,
    output logic [IDXW-1:0]            out_idx,
    output logic signed [15:0]         out_phase
);
    localparam int SUMW = SAMPLE_W + 2 + $clog2(PILOT_LEN);

    logic                   blk_done;
    logic signed [SUMW-1:0] blk_sum_i, blk_sum_q;
    logic                   est_valid;
    phase_t                 est_phase;

    pai_pilot_accum #(
        .SW       (SAMPLE_W),
        .PILOT_LEN(PILOT_LEN),
        .SUMW     (SUMW)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_i     (in_i),
        .in_q     (in_q),
        .in_pilot (in_pilot),
        .ref_i_neg(ref_i_neg),
        .ref_q_neg(ref_q_neg),
        .blk_done (blk_done),
        .blk_sum_i(blk_sum_i),
        .blk_sum_q(blk_sum_q)
    );

    pai_cordic_vec #(
        .IW  (SUMW),
        .ITER(CORDIC_ITER)
    ) u_cordic (
        .clk  (clk),
        .rst_n(rst_n),
        .start(blk_done),
        .x_in (blk_sum_i),
        .y_in (blk_sum_q),
        .done (est_valid),
        .angle(est_phase)
    );

    pai_interp #(
        .DATA_LEN(DATA_LEN),
        .IDXW    (IDXW),
        .RS      (RECIP_SHIFT)
    ) u_interp (
        .clk      (clk),
        .rst_n    (rst_n),
        .est_valid(est_valid),
        .est_phase(est_phase),
        .out_valid(out_valid),
        .out_idx  (out_idx),
        .out_phase(out_phase)
    );

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_idx == IDXW'(1)));

endmodule

// File: tb/pilot_phase_interp_bench.sv
module pilot_phase_interp_bench;
    localparam int SW   = 12;
    localparam int P    = 4;
    localparam int N    = 9;
    localparam int DIST = N + 1;
    localparam int IDXW = $clog2(N + 1);
    localparam int TOL  = 24;
    localparam real PI  = 3.14159265358979;
    localparam real AMP = 700.0;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [SW-1:0] in_i = '0;
    logic signed [SW-1:0] in_q = '0;
    logic                 in_pilot = 1'b0;
    logic                 ref_i_neg = 1'b0;
    logic                 ref_q_neg = 1'b0;
    logic                 out_valid;
    logic [IDXW-1:0]      out_idx;
    logic signed [15:0]   out_phase;

    int checks = 0;
    int fails  = 0;
    int out_cnt = 0;
    int ph_prev = 0;
    int ph_cur  = 0;
    logic last_valid = 1'b0;

    always #4 clk = ~clk;

    pilot_phase_interp #(
        .SAMPLE_W   (SW),
        .PILOT_LEN  (P),
        .DATA_LEN   (N),
        .CORDIC_ITER(14),
        .RECIP_SHIFT(28)
    ) u_pilot_phase_interp (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_i     (in_i),
        .in_q     (in_q),
        .in_pilot (in_pilot),
        .ref_i_neg(ref_i_neg),
        .ref_q_neg(ref_q_neg),
        .out_valid(out_valid),
        .out_idx  (out_idx),
        .out_phase(out_phase)
    );

    // R4: 16-bit phase, 32768 = pi
    function automatic int wrap16(input int v);
        int m;
        m = ((v % 65536) + 65536) % 65536;
        return (m >= 32768) ? m - 65536 : m;
    endfunction

    function automatic int phase_of(input int sx, input int sy);
        real a;
        a = $atan2(real'(sy), real'(sx));
        return wrap16(int'(a * 32768.0 / PI));
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // R6 R7: expected interpolated phase
    function automatic int expect_at(input int i);
        int d;
        d = wrap16(ph_cur - ph_prev);
        return wrap16(ph_prev + int'(real'(d) * real'(i) / real'(DIST)));
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                int e, err;
                checks++;
                e   = expect_at(out_cnt + 1);
                err = wrap16(int'(out_phase) - e);
                if (int'(out_idx) != out_cnt + 1 || iabs(err) > TOL) begin
                    fails++;
                    $display("FAIL R3/R6/R7/R9 idx act=%0d exp=%0d phase act=%0d exp=%0d",
                             out_idx, out_cnt + 1, out_phase, e);
                end
                if (out_cnt > 0 && !last_valid) begin
                    fails++;
                    $display("FAIL R5 gap in sweep act=0 exp=1 at idx %0d", out_cnt + 1);
                end
                out_cnt++;
            end
            last_valid = out_valid;
        end
    end

    task automatic drive(input logic v, input logic p, input int i, input int q, input int code);
        @(posedge clk);
        #1;
        in_valid  = v;
        in_pilot  = p;
        in_i      = SW'(i);
        in_q      = SW'(q);
        ref_i_neg = code[0];
        ref_q_neg = code[1];
    endtask

    // Sends a data gap then one pilot block rotated by deg; returns expected estimate
    task automatic send_frame(input int deg, input int f, output int est);
        int sx, sy;
        sx = 0;
        sy = 0;
        for (int k = 0; k < N; k++) begin
            // R8: full-scale junk on non-pilot samples
            drive(1'b1, 1'b0, (k % 2) ? 2047 : -2048, (k % 3) ? -2048 : 2047, k % 4);
        end
        for (int k = 0; k < P; k++) begin
            int code, a, b, ri, rq;
            real th;
            code = (f + k) % 4;
            a  = code[0] ? -1 : 1;
            b  = code[1] ? -1 : 1;
            th = real'(deg) * PI / 180.0 + real'(k) * 0.01;
            ri = int'(AMP * (real'(a) * $cos(th) - real'(b) * $sin(th)));
            rq = int'(AMP * (real'(a) * $sin(th) + real'(b) * $cos(th)));
            sx += ri * a + rq * b;
            sy += rq * a - ri * b;
            drive(1'b1, 1'b1, ri, rq, code);
            // R8: stalled cycle with pilot flag raised and junk values
            if (k % 2 == 0) drive(1'b0, 1'b1, 1500, -1500, code ^ 1);
        end
        drive(1'b0, 1'b0, 0, 0, 0);
        est = phase_of(sx, sy);
    endtask

    initial begin
        int angles[20] = '{0, 40, 170, -170, -100, 95, 5, -5, 120, -50,
                           179, -178, 90, -80, 135, -135, 30, 45, 10, -150};
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                fails++;
                $display("FAIL R1 out_valid after reset act=%b exp=0", out_valid);
            end
        end
        for (int f = 0; f < 20; f++) begin
            int est;
            out_cnt = 0;
            send_frame(angles[f], f, est);
            if (f == 0) begin
                ph_prev = est;
                repeat (40) @(posedge clk);
                @(negedge clk);
                checks++;
                if (out_cnt != 0) begin
                    fails++;
                    $display("FAIL R2 outputs after first block act=%0d exp=0", out_cnt);
                end
            end else begin
                ph_cur = est;
                for (int w = 0; w < 80 && out_cnt < N; w++) @(posedge clk);
                repeat (3) @(posedge clk);
                @(negedge clk);
                checks++;
                if (out_cnt != N) begin
                    fails++;
                    $display("FAIL R5 sweep length act=%0d exp=%0d", out_cnt, N);
                end
                // R9: this block's estimate is the reference for the next one
                ph_prev = ph_cur;
            end
        end
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule